// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block sits on the inbound side of a host bridge and decides, for each address arriving from the external bus, whether that address falls inside one of three programmable memory windows. It also says which window claimed the address and gives the address translated into local space. A fourth register with the same encoding describes the I/O window, which only I/O-space requests consult.

Each register holds a bus-side base (bits 31:20, 1 MB granular) and a 4-bit logarithmic size code. Code k describes a window of 2^(20+k) bytes, so the legal codes 0 to 11 cover 1 MB to 2 GB. Codes 12 to 15 switch the window off. Every window maps to local address zero, so the translated address is the offset of the request inside its window. Base bits below the window size are ignored: the window always lies on a boundary of its own size. A request is presented with a valid strobe, and the result appears one clock later with a one-cycle valid pulse.

Top module: `inbound_window_decoder`

## Requirements
- R1: After reset every register holds base 0 with size code 0xF, so every window is off and every request misses. rsp_valid and rsp_hit are 0.
- R2: A write with cfg_we high stores cfg_wdata[31:20] as the base and cfg_wdata[19:16] as the size code. The byte offset selects the register: 0x50 is window 0, 0x54 is window 1, 0x58 is window 2, and 0x00 is the I/O window. Writes to any other offset change nothing, and cfg_wdata[15:0] is ignored. A write takes effect for requests presented in the following cycle.
- R3: For a legal size code k (0 to 11), the window is 2^(20+k) bytes in size. A memory request hits that window when address bits 31:(20+k) equal base bits 31:(20+k). Base bits below bit 20+k have no effect.
- R4: A size code of 12 to 15 disables its window, whatever the base.
- R5: When several memory windows match, the lowest-numbered window is reported on rsp_win (0, 1 or 2).
- R6: On a hit, rsp_addr is the request address with every bit at or above bit 20+k cleared, which is the offset from local base zero. On a miss, rsp_addr is 0.
- R7: rsp_valid is high exactly in the cycle after a cycle with req_valid high. rsp_hit, rsp_win and rsp_addr are 0 whenever there is no hit.
- R8: A request with req_io high is compared only against the I/O register and reports rsp_win = 3 on a hit. A request with req_io low never hits the I/O register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_off | input | 8 | Byte offset of the register written |
| cfg_wdata | input | 32 | Write data: base in 31:20, size code in 19:16 |
| req_valid | input | 1 | Request strobe |
| req_io | input | 1 | Request targets I/O space |
| req_addr | input | 32 | Inbound bus address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | Address fell in an enabled window |
| rsp_win | output | 2 | Winning window: 0 to 2 for memory, 3 for I/O |
| rsp_addr | output | 32 | Translated local address (offset in window) |

## Verification
The assertions assume that req_io and req_addr are stable and known whenever req_valid is high, and that nobody writes a register in the same cycle as a request that depends on the new value. The result of such a request reflects the old value. The bench drives requests and register writes from tasks on the falling edge and only changes the configuration between requests, so both assumptions hold. The random stimulus draws all sixteen size codes, including the illegal ones. Half of its addresses are pulled close to the programmed bases so that window edges are hit often.

// File: rtl/iwd_pkg.sv
package iwd_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_LSB = 20;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 16;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int MAX_CODE = ADDR_W - 1 - BASE_LSB;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BASE_W-1:0] base_t;
  typedef logic [CODE_W-1:0] code_t;

  // A size code is usable when its window still fits in the address space.
  function automatic logic code_legal(code_t c);
    return int'(c) <= MAX_CODE;
  endfunction

  // Mask of the offset bits inside a window of the given code.
  function automatic addr_t offset_mask(code_t c);
    int sh;
    sh = BASE_LSB + int'(c);
    if (sh >= ADDR_W) return '1;
    return (addr_t'(1) << sh) - addr_t'(1);
  endfunction

  function automatic addr_t base_addr(base_t b);
    return {b, {BASE_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/iwd_cfg_regs.sv
module iwd_cfg_regs
  import iwd_pkg::*;
#(
  parameter int NUM_WIN    = 3,
  parameter int OFF_W      = 8,
  parameter int WIN_OFF0   = 'h50,
  parameter int WIN_STRIDE = 4,
  parameter int IO_OFF     = 'h00,
  localparam int NUM_REG   = NUM_WIN + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [OFF_W-1:0]         cfg_off,
  input  addr_t                    cfg_wdata,
  output base_t [NUM_REG-1:0]      reg_base,
  output code_t [NUM_REG-1:0]      reg_code
);
  logic unused_low_bits;
  assign unused_low_bits = ^cfg_wdata[CODE_LSB-1:0];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    localparam logic [OFF_W-1:0] MY_OFF =
      (r == NUM_WIN) ? OFF_W'(IO_OFF) : OFF_W'(WIN_OFF0 + r * WIN_STRIDE);
    logic sel;
    assign sel = cfg_we && (cfg_off == MY_OFF);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        reg_base[r] <= '0;
        reg_code[r] <= '1;
      end else if (sel) begin
        reg_base[r] <= cfg_wdata[ADDR_W-1:BASE_LSB];
        reg_code[r] <= cfg_wdata[CODE_LSB +: CODE_W];
      end
    end
  end
endmodule

// File: rtl/iwd_win_match.sv
module iwd_win_match
  import iwd_pkg::*;
(
  input  base_t  base,
  input  code_t  code,
  input  addr_t  addr,
  output logic   legal,
  output logic   hit,
  output addr_t  offset
);
  addr_t low;
  assign low    = offset_mask(code);
  assign legal  = code_legal(code);
  assign hit    = legal && (((addr ^ base_addr(base)) & ~low) == '0);
  assign offset = addr & low;
endmodule

// File: rtl/iwd_prio.sv
module iwd_prio #(
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/inbound_window_decoder.sv
module inbound_window_decoder
  import iwd_pkg::*;
#(
  parameter int NUM_WIN   = 3,
  localparam int NUM_REG  = NUM_WIN + 1,
  localparam int WIN_IDX_W = $clog2(NUM_REG),
  localparam int PRIO_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_off,
  input  logic [31:0]          cfg_wdata,
  input  logic                 req_valid,
  input  logic                 req_io,
  input  logic [31:0]          req_addr,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [WIN_IDX_W-1:0] rsp_win,
  output logic [31:0]          rsp_addr
);
  base_t [NUM_REG-1:0] reg_base;
  code_t [NUM_REG-1:0] reg_code;
  logic  [NUM_REG-1:0] legal_vec;
  logic  [NUM_REG-1:0] match_vec;
  addr_t [NUM_REG-1:0] off_vec;

  iwd_cfg_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_off  (cfg_off),
    .cfg_wdata(cfg_wdata),
    .reg_base (reg_base),
    .reg_code (reg_code)
  );

  for (genvar w = 0; w < NUM_REG; w++) begin : g_match
    iwd_win_match u_match (
      .base  (reg_base[w]),
      .code  (reg_code[w]),
      .addr  (req_addr),
      .legal (legal_vec[w]),
      .hit   (match_vec[w]),
      .offset(off_vec[w])
    );
  end

  logic              mem_any;
  logic [PRIO_W-1:0] mem_idx;

  iwd_prio #(.N(NUM_WIN)) u_prio (
    .req(match_vec[NUM_WIN-1:0]),
    .any(mem_any),
    .idx(mem_idx)
  );

  logic                 sel_hit;
  logic [WIN_IDX_W-1:0] sel_win;
  addr_t                sel_off;

  always_comb begin
    if (req_io) begin
      sel_hit = match_vec[NUM_WIN];
      sel_win = WIN_IDX_W'(NUM_WIN);
      sel_off = off_vec[NUM_WIN];
    end else begin
      sel_hit = mem_any;
      sel_win = WIN_IDX_W'(mem_idx);
      sel_off = off_vec[mem_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_win   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && sel_hit;
      rsp_win   <= (req_valid && sel_hit) ? sel_win : '0;
      rsp_addr  <= (req_valid && sel_hit) ? sel_off : '0;
    end
  end
endmodule

// File: rtl/iwd_checker.sv
module iwd_checker #(
  parameter int NUM_WIN = 3,
  localparam int NUM_REG = NUM_WIN + 1,
  localparam int WIN_IDX_W = $clog2(NUM_REG)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_io,
  input logic [31:0]          req_addr,
  input logic [NUM_REG-1:0]   legal_vec,
  input logic [NUM_REG-1:0]   match_vec,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic [WIN_IDX_W-1:0] rsp_win,
  input logic [31:0]          rsp_addr
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_hit_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  assert_miss_zero_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_addr == '0 && rsp_win == '0));
  assert_offset_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_io) |=> ((rsp_addr & ~$past(req_addr)) == '0));
  assert_low_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_io && match_vec[0]) |=> (rsp_hit && rsp_win == '0));
  assert_second_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_io && !match_vec[0] && match_vec[1]) |=>
    (rsp_hit && rsp_win == WIN_IDX_W'(1)));
  assert_io_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_io) |=> (rsp_win != WIN_IDX_W'(NUM_WIN)));
  assert_io_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_io && match_vec[NUM_WIN]) |=>
    (rsp_hit && rsp_win == WIN_IDX_W'(NUM_WIN)));

  for (genvar i = 0; i < NUM_REG; i++) begin : g_off
    assert_illegal_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !legal_vec[i] |-> !match_vec[i]);
  end
endmodule

bind inbound_window_decoder iwd_checker #(.NUM_WIN(NUM_WIN)) u_iwd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_io   (req_io),
  .req_addr (req_addr),
  .legal_vec(legal_vec),
  .match_vec(match_vec),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .rsp_win  (rsp_win),
  .rsp_addr (rsp_addr)
);

// File: tb/inbound_window_decoder_bench.sv
module inbound_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_off = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  // Model state: words as last written, index 3 is the I/O register.
  logic [31:0] mdl_word [4];

  always #2.5 clk = ~clk;

  inbound_window_decoder u_inbound_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_io(req_io),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_win(rsp_win), .rsp_addr(rsp_addr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Window as an address range: start rounded down to a multiple of its size.
  task automatic model(input logic [31:0] a, input bit io,
                       output bit h, output int w, output logic [31:0] o);
    longint unsigned sz, st;
    int code;
    h = 0; w = 0; o = '0;
    for (int i = 0; i < 4; i++) begin
      code = int'(mdl_word[i][19:16]);
      if ((io != (i == 3)) || h || code > 11) continue;
      sz = 64'd1 << (20 + code);
      st = longint'(mdl_word[i][31:20]) << 20;
      st = st - (st % sz);
      if (longint'(a) >= st && longint'(a) < st + sz) begin
        h = 1; w = i; o = 32'(longint'(a) - st);
      end
    end
  endtask

  task automatic wr_cfg(input logic [7:0] off, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_off = off; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (off)
      8'h50: mdl_word[0] = data;
      8'h54: mdl_word[1] = data;
      8'h58: mdl_word[2] = data;
      8'h00: mdl_word[3] = data;
      default: ;
    endcase
  endtask

  task automatic do_req(input string tag, input logic [31:0] a, input bit io);
    bit h; int w; logic [31:0] o;
    model(a, io, h, w, o);
    req_valid = 1'b1; req_io = io; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R7 valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " hit"}, 32'(rsp_hit), 32'(h));
    check({tag, " R5 win"}, 32'(rsp_win), 32'(w));
    check({tag, " R6 addr"}, rsp_addr, o);
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R7 valid after idle", 32'(rsp_valid), 32'd0);
    check("R7 hit after idle", 32'(rsp_hit), 32'd0);
  endtask

  function automatic logic [31:0] win_word(input logic [11:0] base, input int code);
    return {base, 4'(code), 16'(($urandom & 32'hffff))};
  endfunction

  initial begin
    logic [31:0] st, sz, a, nb;
    int sel;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) mdl_word[i] = 32'h000F_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 reset rsp_hit", 32'(rsp_hit), 32'd0);
    do_req("R1 mem after reset", 32'h0000_1234, 1'b0);
    do_req("R1 io after reset", 32'h0000_0010, 1'b1);
    idle_check();

    // R3/R6: both edges of every legal size code on window 1, base low bits junk.
    for (int k = 0; k < 12; k++) begin
      nb = $urandom;
      wr_cfg(8'h54, win_word(nb[11:0], k));
      sz = 32'(64'd1 << (20 + k));
      st = {nb[11:0], 20'h0} & ~(sz - 32'd1);
      do_req("R3 start", st, 1'b0);
      check("R3 start hits", 32'(rsp_hit), 32'd1);
      do_req("R3 last", st + sz - 32'd1, 1'b0);
      check("R6 last offset", rsp_addr, sz - 32'd1);
      if (st != 0) do_req("R3 below", st - 32'd1, 1'b0);
      if (64'(st) + 64'(sz) < 64'h1_0000_0000) begin
        do_req("R3 above", st + sz, 1'b0);
        check("R3 above misses", 32'(rsp_hit), 32'd0);
      end
    end

    // R4: illegal codes switch the window off.
    for (int k = 12; k < 16; k++) begin
      wr_cfg(8'h54, {12'h000, 4'(k), 16'h0});
      do_req("R4 illegal", 32'h0000_0100, 1'b0);
      check("R4 illegal misses", 32'(rsp_hit), 32'd0);
    end

    // R5: overlapping windows.
    wr_cfg(8'h50, {12'h100, 4'd4, 16'h0});
    wr_cfg(8'h54, {12'h100, 4'd6, 16'h0});
    wr_cfg(8'h58, {12'h100, 4'd2, 16'h0});
    do_req("R5 three overlap", 32'h1002_0000, 1'b0);
    check("R5 lowest wins", 32'(rsp_win), 32'd0);
    do_req("R5 outside w0", 32'h1300_0000, 1'b0);
    check("R5 w1 only", 32'(rsp_win), 32'd1);
    wr_cfg(8'h50, 32'h000F_0000);
    do_req("R5 w0 off", 32'h1002_0000, 1'b0);
    check("R5 w1 beats w2", 32'(rsp_win), 32'd1);

    // R2: unmapped offset and ignored low data bits.
    wr_cfg(8'h4C, {12'h200, 4'd0, 16'hFFFF});
    do_req("R2 unmapped write", 32'h2000_0000, 1'b0);
    check("R2 unmapped no hit", 32'(rsp_hit), 32'd0);
    wr_cfg(8'h58, {12'h200, 4'd0, 16'hFFFF});
    do_req("R2 w2 written", 32'h200F_FFFF, 1'b0);
    check("R2 w2 hit", 32'(rsp_win), 32'd2);

    // R8: I/O window only for I/O requests.
    wr_cfg(8'h00, {12'h300, 4'd1, 16'h0});
    do_req("R8 io hit", 32'h3010_0004, 1'b1);
    check("R8 io win", 32'(rsp_win), 32'd3);
    do_req("R8 mem to io range", 32'h3010_0004, 1'b0);
    do_req("R8 io to mem range", 32'h200F_FFFF, 1'b1);
    check("R8 io ignores mem", 32'(rsp_hit), 32'd0);
    idle_check();

    // Random mix.
    for (int n = 0; n < 2000; n++) begin
      if (n % 25 == 0) begin
        for (int i = 0; i < 4; i++) begin
          nb = $urandom;
          wr_cfg(i == 3 ? 8'h00 : 8'(8'h50 + 4 * i), win_word(nb[11:0], int'(nb[15:12])));
        end
        if ($urandom % 4 == 0) wr_cfg(8'($urandom), $urandom);
      end
      sel = int'($urandom % 4);
      a = $urandom;
      if ($urandom % 2 == 0)
        a = {mdl_word[sel][31:20], 20'h0} ^ (a & (32'h1 << ($urandom % 32)) - 32'h1);
      do_req("R3 random", a, ($urandom % 5) == 0);
      if ($urandom % 8 == 0) idle_check();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule